// File: doc/BRIEF.md
# Condition Transition Event Register

This block watches a vector of live instrument condition bits and records every change for a host. Falling and rising transitions go into two separate latch registers. Each latch register has its own host-writable enable mask. A bit that is latched and also enabled raises a change-summary bit in a small status byte. The block also holds an event status register. A pulse on an event input sets the matching bit, and bit 5 is used for a malformed command. An eight-bit enable mask gates that register into a second summary bit at position 5 of the status byte.

The host reaches the block through a plain register bus that has read and write strobes, a 3-bit register select and write data. Read data is registered. It appears on `bus_rdata` on the cycle after the read strobe and holds there until the next read. Every access completes in a single cycle, so the bus has no back-pressure and no handshake. Reading either latch register or the event register clears it. A clear-status pulse also clears all three, but it leaves the masks alone.

Top module: `stat_xition_evt`

## Requirements
- R1: A condition bit that goes from 1 to 0 sets its bit in the falling latch (select 1) one clock edge after the change is sampled. The latch then holds that bit until it is cleared.
- R2: A condition bit that goes from 0 to 1 sets its bit in the rising latch (select 2). It follows the same timing as R1.
- R3: The falling latch, the rising latch and the event register (select 5) read as 0 after reset. A read of one of them returns its contents and then clears it. A `clr_stat` pulse clears all three.
- R4: Status byte bit 0 is 1 exactly when some bit is set in both a latch and its own mask. The falling latch uses mask select 3 and the rising latch uses mask select 4. The bit drops as soon as the latch is cleared or the mask is zeroed.
- R5: While both masks are 0, status byte bit 0 never becomes 1, whatever transitions occur.
- R6: All masks reset to 0 and can be written by the host. `clr_stat` leaves them unchanged.
- R7: A pulse on `evt_set[5]` records a malformed command in bit 5 of the event register. Status byte bit 5 is 1 exactly when the event register and the event mask (select 6) have a bit in common.
- R8: Clearing an event mask bit drops status byte bit 5, but the event bit stays recorded and can be read.
- R9: A transition that arrives in the same cycle as a read or a clear-status of its latch is kept. Only the contents returned by the read are cleared.
- R10: Writes to the latch or event selects have no effect. Reading the live condition (select 0) has no side effect. An unused select (7) reads as 0.
- R11: Condition bits that are already high at reset are not reported as rising transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond | input | 16 | Live condition vector |
| evt_set | input | 8 | Event set pulses; bit 5 marks a malformed command |
| clr_stat | input | 1 | Clear-status pulse |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Registered read data |
| stat_byte | output | 8 | Bit 0 is the change summary, bit 5 is the event summary, other bits are 0 |

## Verification
The hardest case to reach is a transition that lands in the very cycle that a read is clearing its latch. The stimulus first leaves an older rising bit in the latch. It then changes the condition vector on the same falling clock edge that raises the read strobe. Two reads follow. The first must return only the older bit, and the second must return only the new one. A second hard case is a condition bit that is already high when reset ends. It is held across reset, and the rising latch is then checked to show that nothing was reported.

// File: rtl/stat_xition_pkg.sv
package stat_xition_pkg;
  typedef enum logic [2:0] {
    SEL_COND = 3'd0,
    SEL_FALL = 3'd1,
    SEL_RISE = 3'd2,
    SEL_FEN  = 3'd3,
    SEL_REN  = 3'd4,
    SEL_EVT  = 3'd5,
    SEL_EEN  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/xition_detect.sv
module xition_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= cond_i;
      primed_q <= 1'b1;
    end
  end

  // No edges until a first sample has been taken after reset.
  assign fall_o = primed_q ? (prev_q & ~cond_i) : '0;
  assign rise_o = primed_q ? (~prev_q & cond_i) : '0;
endmodule

// File: rtl/sticky_latch.sv
module sticky_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         rd_clr_i,
  input  logic         cls_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= ((rd_clr_i || cls_i) ? '0 : q) | set_i;
  end

  assign q_o = q;

  // R9: fresh set bits always land, even during a clear
  p_set_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  // R3: a clear leaves only what arrived in that cycle
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i || cls_i) |=> (q_o == $past(set_i)));
  // R1: without a clear nothing latched is lost
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_clr_i || cls_i) |=> ((q_o & $past(q_o)) == $past(q_o)));
endmodule

// File: rtl/stat_xition_evt.sv
module stat_xition_evt
  import stat_xition_pkg::*;
#(
  parameter int W       = 16,
  parameter int EW      = 8,
  parameter int CHG_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cond,
  input  logic [EW-1:0] evt_set,
  input  logic          clr_stat,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [7:0]    stat_byte
);
  localparam int EVT_BIT = 5;
  localparam int PAD     = W - EW;

  logic [W-1:0]  fall_edge, rise_edge, fall_q, rise_q;
  logic [W-1:0]  fall_en, rise_en;
  logic [EW-1:0] evt_q, evt_en;
  logic [W-1:0]  rdata_q;
  logic          rd_fall, rd_rise, rd_evt;
  logic          chg_sum, evt_sum;

  xition_detect #(.W(W)) u_det (
    .clk(clk), .rst_n(rst_n), .cond_i(cond),
    .fall_o(fall_edge), .rise_o(rise_edge)
  );

  assign rd_fall = bus_rd && (bus_addr == SEL_FALL);
  assign rd_rise = bus_rd && (bus_addr == SEL_RISE);
  assign rd_evt  = bus_rd && (bus_addr == SEL_EVT);

  sticky_latch #(.W(W)) u_fall (
    .clk(clk), .rst_n(rst_n), .set_i(fall_edge),
    .rd_clr_i(rd_fall), .cls_i(clr_stat), .q_o(fall_q)
  );
  sticky_latch #(.W(W)) u_rise (
    .clk(clk), .rst_n(rst_n), .set_i(rise_edge),
    .rd_clr_i(rd_rise), .cls_i(clr_stat), .q_o(rise_q)
  );
  sticky_latch #(.W(EW)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set),
    .rd_clr_i(rd_evt), .cls_i(clr_stat), .q_o(evt_q)
  );

  // Masks: host-writable, touched only by reset otherwise.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fall_en <= '0;
      rise_en <= '0;
      evt_en  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        SEL_FEN: fall_en <= bus_wdata;
        SEL_REN: rise_en <= bus_wdata;
        SEL_EEN: evt_en  <= bus_wdata[EW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        SEL_COND: rdata_q <= cond;
        SEL_FALL: rdata_q <= fall_q;
        SEL_RISE: rdata_q <= rise_q;
        SEL_FEN:  rdata_q <= fall_en;
        SEL_REN:  rdata_q <= rise_en;
        SEL_EVT:  rdata_q <= {{PAD{1'b0}}, evt_q};
        SEL_EEN:  rdata_q <= {{PAD{1'b0}}, evt_en};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign chg_sum   = |(fall_q & fall_en) || |(rise_q & rise_en);
  assign evt_sum   = |(evt_q & evt_en);

  always_comb begin
    stat_byte          = '0;
    stat_byte[CHG_BIT] = chg_sum;
    stat_byte[EVT_BIT] = evt_sum;
  end

  // R5: with both masks cleared the change summary stays low
  p_summary_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_en == '0 && rise_en == '0) |-> !stat_byte[CHG_BIT]);
  // R6: clear-status never disturbs the masks
  p_cls_keeps_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat && !bus_wr) |=> ($stable(fall_en) && $stable(rise_en) && $stable(evt_en)));
  // R10: a write to the falling latch select is ignored
  p_latch_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && !clr_stat && bus_addr == SEL_FALL && fall_edge == '0)
      |=> $stable(fall_q));
  // R8: a zero event mask keeps the event summary low
  p_evt_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_en == '0) |-> !stat_byte[EVT_BIT]);
endmodule

// File: tb/stat_xition_evt_test.sv
module stat_xition_evt_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cond = 16'hF0F0;
  logic [7:0]  evt_set = '0;
  logic        clr_stat = 0, bus_wr = 0, bus_rd = 0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  stat_byte;

  int checks = 0, fails = 0;
  bit done = 0;
  bit rd_seen = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  stat_xition_evt uut (
    .clk(clk), .rst_n(rst_n), .cond(cond), .evt_set(evt_set), .clr_stat(clr_stat),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stat_byte(stat_byte)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected read result per completed read.
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) chk(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
  end

  // Driver tasks: called at a falling edge, return at a falling edge.
  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    bus_rd = 1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic step(input logic [15:0] c);
    cond = c;
    @(negedge clk);
  endtask

  task automatic cls();
    clr_stat = 1;
    @(negedge clk);
    clr_stat = 0;
  endtask

  task automatic evt(input logic [7:0] v);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R6 status byte after reset", int'(stat_byte), 0);
    rd(3'd3, 0, "R6 falling mask reset");
    rd(3'd4, 0, "R6 rising mask reset");
    rd(3'd2, 0, "R11 no rise from reset level");
    rd(3'd5, 0, "R3 event reset");

    step(16'hF0C0);
    rd(3'd1, 16'h0030, "R1 falling latched");
    rd(3'd1, 0, "R3 falling cleared by read");
    step(16'hF0C3);
    rd(3'd2, 16'h0003, "R2 rising latched");

    step(16'h0F0F); chk("R5 quiet a", int'(stat_byte[0]), 0);
    step(16'hFFFF); chk("R5 quiet b", int'(stat_byte[0]), 0);
    step(16'h0000); chk("R5 quiet c", int'(stat_byte[0]), 0);
    cls();
    rd(3'd1, 0, "R3 falling cleared by clear-status");
    rd(3'd2, 0, "R3 rising cleared by clear-status");

    wr(3'd4, 16'h0100);
    step(16'h0200); chk("R4 unmasked bit ignored", int'(stat_byte[0]), 0);
    step(16'h0300); chk("R4 masked rise sets summary", int'(stat_byte[0]), 1);
    rd(3'd2, 16'h0300, "R4 rising contents");
    chk("R4 summary drops after read", int'(stat_byte[0]), 0);
    wr(3'd3, 16'h0001);
    step(16'h0301);
    step(16'h0300); chk("R4 masked fall sets summary", int'(stat_byte[0]), 1);
    wr(3'd3, 16'h0000); chk("R4 summary drops on mask clear", int'(stat_byte[0]), 0);
    rd(3'd1, 16'h0001, "R4 falling kept after mask clear");

    wr(3'd4, 16'h00FF);
    cls();
    rd(3'd4, 16'h00FF, "R6 mask survives clear-status");

    step(16'h0310);
    cond = 16'h0314;
    rd(3'd2, 16'h0010, "R9 read returns older bit");
    rd(3'd2, 16'h0004, "R9 same-cycle edge kept");

    evt(8'h20); chk("R7 event masked", int'(stat_byte[5]), 0);
    wr(3'd6, 16'h0020); chk("R7 event summary", int'(stat_byte[5]), 1);
    wr(3'd6, 16'h0000); chk("R8 summary drops", int'(stat_byte[5]), 0);
    rd(3'd5, 16'h0020, "R8 event still recorded");
    rd(3'd5, 0, "R3 event cleared by read");

    step(16'h0315);
    wr(3'd1, 16'hFFFF);
    wr(3'd2, 16'h0000);
    wr(3'd5, 16'h00FF);
    rd(3'd1, 0, "R10 falling write ignored");
    rd(3'd0, 16'h0315, "R10 condition read");
    rd(3'd0, 16'h0315, "R10 condition read repeat");
    rd(3'd2, 16'h0001, "R10 rising write ignored");
    rd(3'd5, 0, "R10 event write ignored");
    rd(3'd7, 0, "R10 unused select");

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule